// File: doc/BRIEF.md
# Bias DAC Two-Wire Sender over Serial Register Frames

This block sets the common-voltage bias DAC of a display panel. The DAC listens on an I2C-like two-wire link that nobody can read back. Its clock and data wires are not pins of this chip. They are two bits of one control register inside a display timing controller, and that register is written through 8-bit SPI-style frames. Every level change on the emulated wires therefore costs one complete register-write frame, followed by a settling wait.

A single-cycle `startPulse` begins a transaction. On that pulse the block latches a 3-bit value for the upper control bits of the register and the 8-bit DAC code. It then produces the whole sequence of frames, 87 in total:

- a start condition;
- the device byte 0x9C;
- the command byte 0x00;
- the DAC code;
- a stop condition.

A blind acknowledge clock follows each byte. `busy` covers the whole transaction, and `done` pulses once when it ends.

Top module: `biasdac_wire_sender`

## Requirements
- R1: Every frame is 8 bits. Bits 7:5 hold register address 3. Bits 4:2 hold the base value latched at start. Bit 1 is the emulated data wire (SDA) and bit 0 is the emulated clock wire (SCL).
- R2: A frame is sent MSB first with `csN` low for exactly 16 clock cycles. In that window `sck` gives 8 rising edges and `mosi` holds steady while `sck` is high. Outside a frame, `csN` is high and `sck` is low.
- R3: After every frame, including the last, `csN` stays high for at least SETTLE_US*CYCLES_PER_US cycles before the next frame or `done`.
- R4: A start condition is three frames with (SDA,SCL) = (1,1), then (0,1), then (0,0).
- R5: Each byte bit b is three frames with (SDA,SCL) = (b,0), (b,1), (b,0). Bytes go out MSB first.
- R6: Each acknowledge slot is one bit sent with SDA = 0 (frames (0,0),(0,1),(0,0)). Nothing is sampled.
- R7: A transaction is start, 0x9C, ack, 0x00, ack, DAC code, ack, stop: 87 frames in all.
- R8: A stop condition is three frames with (SDA,SCL) = (0,0), then (0,1), then (1,1).
- R9: `busy` rises the cycle after an accepted `startPulse` and stays high until the last settling wait ends. `done` is high for exactly one cycle, with `busy` already low. An idle block sends no frames.
- R10: A `startPulse` while busy is ignored. A change of `baseBits` or `dacValue` after the start has no effect on the frames.
- R11: Reset (active-low, asynchronous) forces `csN`=1, `sck`=0, `mosi`=0, `busy`=0 and `done`=0, and aborts any transaction.
- R12: Between consecutive frames at most one of SDA and SCL changes. The link idles at (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin a transaction |
| baseBits | input | 3 | Upper control bits placed in frame bits 4:2 |
| dacValue | input | 8 | Bias DAC code, sent as the third byte |
| csN | output | 1 | Frame select, low during a frame |
| sck | output | 1 | Serial clock, data taken on rising edge |
| mosi | output | 1 | Serial data, MSB first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The assertions take three things for granted about the inputs.

- `startPulse` may come at any time, but only a pulse seen while idle starts a transaction.
- The settling wait is at least one cycle.
- The frame shifter is only loaded while idle. The sequencer guarantees this, and an assertion watches it.

The stimulus gives single-cycle start pulses, including one in mid-transaction with different inputs. It changes `baseBits` and `dacValue` after a start. It uses a short settling wait so that many full transactions fit in the run. It also applies one reset in the middle of a transaction.

// File: rtl/biasdac_pkg.sv
package biasdac_pkg;
  localparam int FRAME_BITS = 8;
  localparam int TXN_BYTES  = 3;                // device byte, command byte, DAC code
  localparam int SLOT_BITS  = 9;                // 8 data bits plus one blind ack
  localparam logic [2:0] WIRE_REG_ADDR = 3'd3;  // register holding the two wires
  localparam logic [7:0] DEVICE_BYTE = 8'h9C;
  localparam logic [7:0] COMMAND_BYTE = 8'h00;

  typedef enum logic [1:0] {SEG_START, SEG_BYTE, SEG_STOP} segment_e;

  typedef struct packed {
    logic                  load;   // start shifting one frame
    logic [FRAME_BITS-1:0] frame;  // frame contents for that load
  } dpCmd_t;
endpackage

// File: rtl/biasdac_shift_dp.sv
module biasdac_shift_dp
  import biasdac_pkg::*;
#(
  parameter int WAIT_CYCLES = 1000
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   frameDone,
  output logic   dpIdle,
  output logic   csN,
  output logic   sck,
  output logic   mosi
);
  localparam int CNT_W  = $clog2(FRAME_BITS);
  localparam int WAIT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(WAIT_CYCLES - 1);

  typedef enum logic [1:0] {DP_IDLE, DP_SHIFT, DP_WAIT} dpState_e;

  dpState_e              state;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]      bitCnt;
  logic                  phaseHi;
  logic [WAIT_W-1:0]     waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= DP_IDLE;
      shiftReg <= '0;
      bitCnt   <= '0;
      phaseHi  <= 1'b0;
      sck      <= 1'b0;
      csN      <= 1'b1;
      waitCnt  <= '0;
    end else begin
      case (state)
        DP_IDLE: if (cmd.load) begin
          shiftReg <= cmd.frame;
          csN      <= 1'b0;
          bitCnt   <= '0;
          phaseHi  <= 1'b0;
          state    <= DP_SHIFT;
        end
        DP_SHIFT: begin
          if (!phaseHi) begin
            sck     <= 1'b1;
            phaseHi <= 1'b1;
          end else begin
            sck      <= 1'b0;
            phaseHi  <= 1'b0;
            shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
            if (bitCnt == LAST_BIT) begin
              csN     <= 1'b1;
              waitCnt <= '0;
              state   <= DP_WAIT;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        DP_WAIT: begin
          if (waitCnt == LAST_WAIT) state <= DP_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
        default: state <= DP_IDLE;
      endcase
    end
  end

  assign mosi      = shiftReg[FRAME_BITS-1];
  assign dpIdle    = (state == DP_IDLE);
  assign frameDone = (state == DP_WAIT) && (waitCnt == LAST_WAIT);

  // Checker counters for frame length and inter-frame gap
  localparam int LEN_W = $clog2(2 * FRAME_BITS + 2);
  localparam int GAP_W = WAIT_W + 2;
  logic [LEN_W-1:0] lowLen;
  logic [GAP_W-1:0] highLen;
  logic             seenFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen    <= '0;
      highLen   <= '0;
      seenFrame <= 1'b0;
    end else begin
      lowLen  <= csN ? '0 : lowLen + 1'b1;
      highLen <= !csN ? '0 : ((&highLen) ? highLen : highLen + 1'b1);
      if (!csN) seenFrame <= 1'b1;
    end
  end

  p_sck_framed_r2: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);
  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && !$fell(sck)) |-> $stable(mosi));
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (lowLen == LEN_W'(2 * FRAME_BITS)));
  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && seenFrame) |-> (highLen >= GAP_W'(WAIT_CYCLES)));
endmodule

// File: rtl/biasdac_seq_ctl.sv
module biasdac_seq_ctl
  import biasdac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [2:0] baseBits,
  input  logic [7:0] dacValue,
  input  logic       frameDone,
  input  logic       dpIdle,
  output dpCmd_t     cmd,
  output logic       busy,
  output logic       done
);
  localparam int BYTE_W = $clog2(TXN_BYTES);
  localparam int SLOT_W = $clog2(SLOT_BITS);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(TXN_BYTES - 1);
  localparam logic [SLOT_W-1:0] ACK_SLOT  = SLOT_W'(SLOT_BITS - 1);

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_PEND} ctlState_e;

  ctlState_e         state;
  segment_e          seg;
  logic [BYTE_W-1:0] byteIdx;
  logic [SLOT_W-1:0] bitIdx;
  logic [1:0]        phase;
  logic [2:0]        baseQ;
  logic [7:0]        dacQ;
  logic [1:0]        prevWire;   // {sda, scl} of the last issued frame
  logic [7:0]        curByte;
  logic              bitVal, sda, scl, lastFrame;

  always_comb begin
    case (byteIdx)
      BYTE_W'(0): curByte = DEVICE_BYTE;
      BYTE_W'(1): curByte = COMMAND_BYTE;
      default:    curByte = dacQ;
    endcase
    bitVal = (bitIdx == ACK_SLOT) ? 1'b0 : curByte[3'd7 - bitIdx[2:0]];
    case (seg)
      SEG_START: begin sda = (phase == 2'd0); scl = (phase != 2'd2); end
      SEG_STOP:  begin sda = (phase == 2'd2); scl = (phase != 2'd0); end
      default:   begin sda = bitVal;          scl = (phase == 2'd1); end
    endcase
    lastFrame = (seg == SEG_STOP) && (phase == 2'd2);
    cmd.load  = (state == C_ISSUE);
    cmd.frame = {WIRE_REG_ADDR, baseQ, sda, scl};
  end

  assign busy = (state != C_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= C_IDLE;
      seg      <= SEG_START;
      byteIdx  <= '0;
      bitIdx   <= '0;
      phase    <= '0;
      baseQ    <= '0;
      dacQ     <= '0;
      prevWire <= 2'b11;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        C_IDLE: if (startPulse) begin
          baseQ   <= baseBits;
          dacQ    <= dacValue;
          seg     <= SEG_START;
          byteIdx <= '0;
          bitIdx  <= '0;
          phase   <= '0;
          state   <= C_ISSUE;
        end
        C_ISSUE: begin
          prevWire <= {sda, scl};
          state    <= C_PEND;
        end
        C_PEND: if (frameDone) begin
          if (lastFrame) begin
            done  <= 1'b1;
            state <= C_IDLE;
          end else begin
            state <= C_ISSUE;
            if (phase != 2'd2) begin
              phase <= phase + 1'b1;
            end else begin
              phase <= '0;
              if (seg == SEG_START) begin
                seg <= SEG_BYTE;
              end else if (bitIdx != ACK_SLOT) begin
                bitIdx <= bitIdx + 1'b1;
              end else begin
                bitIdx <= '0;
                if (byteIdx != LAST_BYTE) byteIdx <= byteIdx + 1'b1;
                else seg <= SEG_STOP;
              end
            end
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  p_one_wire_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> ($countones({sda, scl} ^ prevWire) <= 1));
  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> dpIdle);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> ($stable(baseQ) && $stable(dacQ)));
endmodule

// File: rtl/biasdac_wire_sender.sv
module biasdac_wire_sender
  import biasdac_pkg::*;
#(
  parameter int CYCLES_PER_US = 100,
  parameter int SETTLE_US     = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [2:0] baseBits,
  input  logic [7:0] dacValue,
  output logic       csN,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done
);
  localparam int WAIT_CYCLES = CYCLES_PER_US * SETTLE_US;

  dpCmd_t cmd;
  logic   frameDone, dpIdle;

  biasdac_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .baseBits(baseBits),
    .dacValue(dacValue), .frameDone(frameDone), .dpIdle(dpIdle),
    .cmd(cmd), .busy(busy), .done(done)
  );

  biasdac_shift_dp #(.WAIT_CYCLES(WAIT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameDone(frameDone),
    .dpIdle(dpIdle), .csN(csN), .sck(sck), .mosi(mosi)
  );
endmodule

// File: tb/tb_biasdac_wire_sender.sv
`timescale 1ns/1ps
module tb_biasdac_wire_sender;
  localparam int CPU  = 2;
  localparam int SUS  = 10;
  localparam int WAIT = CPU * SUS;
  localparam int NFRAMES = 87;

  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0;
  logic [2:0] baseBits = '0;
  logic [7:0] dacValue = '0;
  logic csN, sck, mosi, busy, done;

  biasdac_wire_sender #(.CYCLES_PER_US(CPU), .SETTLE_US(SUS)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .baseBits(baseBits),
    .dacValue(dacValue), .csN(csN), .sck(sck), .mosi(mosi), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;   // 250 MHz

  int total = 0, bad = 0;

  // {base, dac, expected frame 57 = first frame of the DAC byte's MSB}
  localparam logic [18:0] VEC [4] = '{
    {3'b000, 8'h00, 8'h60},
    {3'b111, 8'hFF, 8'h7E},
    {3'b101, 8'h7D, 8'h74},
    {3'b010, 8'hA5, 8'h6A}
  };

  // Bus monitor, sampled on the falling edge
  logic [7:0] rxFrames [1024];
  logic [7:0] shiftIn = '0;
  logic prevCs = 1'b1;
  int rxCount = 0, bitsIn = 0, lowLen = 0, highLen = WAIT;
  int framingBad = 0, gapBad = 0, doneCount = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs = 1'b1; bitsIn = 0; lowLen = 0; highLen = WAIT;
    end else begin
      if (!csN) begin
        if (prevCs && highLen < WAIT) gapBad++;
        lowLen++;
        if (sck) begin shiftIn = {shiftIn[6:0], mosi}; bitsIn++; end
      end else if (!prevCs) begin
        rxFrames[rxCount % 1024] = shiftIn;
        if (bitsIn != 8 || lowLen != 16) framingBad++;
        rxCount++; bitsIn = 0; lowLen = 0; highLen = 1;
      end else if (highLen < 100000) begin
        highLen++;
      end
      if (done) begin
        doneCount++;
        if (highLen < WAIT) gapBad++;
      end
      prevCs = csN;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expFrame(input int idx, input logic [2:0] b,
                                          input logic [7:0] d);
    logic sda, scl;
    if (idx < 3) begin
      sda = (idx == 0); scl = (idx != 2);
    end else if (idx < 84) begin
      int k = idx - 3;
      int byteI = k / 27;
      int bitI = (k % 27) / 3;
      int ph = k % 3;
      logic [7:0] by = (byteI == 0) ? 8'h9C : (byteI == 1) ? 8'h00 : d;
      sda = (bitI < 8) ? by[7 - bitI] : 1'b0;
      scl = (ph == 1);
    end else begin
      sda = (idx == 86); scl = (idx != 84);
    end
    return {3'd3, b, sda, scl};
  endfunction

  function automatic string regionTag(input int idx);
    int k = idx - 3;
    if (idx < 3) return "R4 start";
    if (idx >= 84) return "R8 stop";
    if ((k % 27) / 3 == 8) return "R6 ack";
    return "R5 data bit";
  endfunction

  task automatic runTxn(input logic [2:0] b, input logic [7:0] d,
                        input logic [7:0] exp57, input bit restart);
    int s0 = rxCount, fb0 = framingBad, gb0 = gapBad, d0 = doneCount, n = 0;
    @(negedge clk); baseBits = b; dacValue = d; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    if (restart) begin
      repeat (300) @(negedge clk);
      baseBits = ~b; dacValue = ~d; startPulse = 1'b1;   // R10: ignored
      @(negedge clk); startPulse = 1'b0;
    end else begin
      baseBits = ~b; dacValue = ~d;                       // R10: late change
    end
    do begin @(negedge clk); n++; end while (!done && n < 20000);
    chk(done === 1'b1, "R9", "done reached", done, 1);
    chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", done, 0);
    chk(doneCount - d0 == 1, "R9", "done pulses", doneCount - d0, 1);
    chk(rxCount - s0 == NFRAMES, "R7", "frame count", rxCount - s0, NFRAMES);
    chk(framingBad == fb0, "R2", "frame framing errors", framingBad - fb0, 0);
    chk(gapBad == gb0, "R3", "short settle gaps", gapBad - gb0, 0);
    for (int i = 0; i < NFRAMES; i++) begin
      logic [7:0] got = rxFrames[(s0 + i) % 1024];
      logic [7:0] exp = expFrame(i, b, d);
      chk(got === exp, {"R1 R7 R10 ", regionTag(i)}, $sformatf("frame %0d", i), got, exp);
      if (i > 0) begin
        logic [7:0] prv = rxFrames[(s0 + i - 1) % 1024];
        chk($countones(got[1:0] ^ prv[1:0]) <= 1, "R12", "one wire per frame",
            got[1:0] ^ prv[1:0], 0);
      end
    end
    chk(rxFrames[(s0 + 57) % 1024] === exp57, "R5", "DAC MSB frame",
        rxFrames[(s0 + 57) % 1024], exp57);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk(csN === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R11", "reset bus idle",
        {csN, sck, mosi}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0, "R11", "reset status", {busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 4; v++)
      runTxn(VEC[v][18:16], VEC[v][15:8], VEC[v][7:0], 1'b0);

    runTxn(3'b110, 8'h3C, 8'h78, 1'b1);   // R10 mid-transaction start

    c0 = rxCount;                          // R9: idle sends nothing
    repeat (200) @(negedge clk);
    chk(rxCount == c0 && busy === 1'b0, "R9", "idle frames", rxCount - c0, 0);

    @(negedge clk); baseBits = 3'b001; dacValue = 8'h55; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    repeat (500) @(negedge clk);
    rstN = 1'b0;                           // R11: abort by reset
    @(negedge clk);
    chk(csN === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R11", "abort bus idle",
        {csN, sck, mosi}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0, "R11", "abort status", {busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runTxn(3'b011, 8'h80, 8'h6E, 1'b0);   // after abort, full sequence again

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule